// File: doc/BRIEF.md
# Single-wire pulse frame decoder

This block turns a pulse-coded serial stream on one data wire into an eight-bit word. The wire rests high. A frame opens with a low start pulse about two bit times long. A run of four-bit units follows. Each unit is a high synchronizing bit, one information bit, and two low zero bits. The block runs on a sample clock at four times the transmit bit rate, so one bit spans four clock cycles. It checks the width of the start pulse. It restarts its unit timing on the rising edge that opens every unit, so an error in the clock ratio cannot pile up across the frame. It reads the information bit near the middle of that bit.

A completed word appears on `data_out` together with a one-cycle `frame_valid` strobe. A start pulse that fails the width check raises a one-cycle `frame_error`, and so does a frame that breaks off before its last wanted unit. The mode input picks the part of a sixteen-unit frame that belongs to this receiver. Master or stand-alone mode takes the first eight units. Slave mode takes units eight to fifteen. A later stage compares successive words, and that stage is not part of this block.

Top module: `pulse_frame_rx`

## Requirements
- R1: During reset and right after it, `data_out` is 0 and both strobes are low. The decoder starts to look for a start pulse only once `rx_line` has been high on 12 consecutive samples. A frame that begins before that produces neither strobe.
- R2: A low run of 6 to 10 samples starts a frame. A low run shorter than 6 samples raises `frame_error`, and the decoder at once watches for the next falling edge, so a correct frame that follows closely is still decoded.
- R3: A low run longer than 10 samples raises `frame_error`. The decoder then waits for 12 consecutive high samples, and the units that follow are ignored.
- R4: A unit's information bit is the line level on the fifth sample after the sample that first sees the unit's rising edge. High reads as 1 (switch open) and low reads as 0 (switch closed).
- R5: Unit timing restarts at every unit's rising edge. The next unit's rising edge is accepted 12 to 20 samples after the previous one. If no rising edge comes within 20 samples, the frame is rejected with `frame_error`.
- R6: With `slave_mode` = 0, units 0 to 7 are captured, and unit k lands in `data_out[k]`. `frame_valid` is high for exactly one cycle: the cycle after unit 7 is sampled.
- R7: With `slave_mode` = 1, units 8 to 15 are captured, and unit 8+k lands in `data_out[k]`. Units 0 to 7 are decoded but not stored.
- R8: A frame that breaks off early gives one `frame_error` and no `frame_valid`. `data_out` changes only together with `frame_valid`, so it keeps the last good word.
- R9: A rising edge that comes before the information bit has been sampled is a fault. So is one that comes fewer than 12 samples after the unit's rising edge. Either one rejects the frame with `frame_error`.
- R10: Frames are decoded correctly when the transmit bit time is 15 % shorter or longer than four sample periods.
- R11: Once a word has been delivered, low runs inside the rest of the frame are not taken as start pulses. In master mode a sixteen-unit frame therefore gives exactly one `frame_valid` and no `frame_error`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock at four times the transmit bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Data wire, idles high, synchronous to `clk` |
| slave_mode | input | 1 | 0: capture the first eight units; 1: capture the second eight |
| data_out | output | 8 | Last accepted word, unit k of the window in bit k |
| frame_valid | output | 1 | One-cycle strobe when a new word is on `data_out` |
| frame_error | output | 1 | One-cycle strobe on a rejected start pulse or broken frame |

## Verification
Two things can fall on the same sample: the rising edge that starts the next unit, and the point at which the current information bit is read. The bench provokes this with a unit whose high sync bit is followed by only one sample period of low, so the next rising edge is first seen exactly at the sampling phase. The decoder must let the edge win, reject the frame with `frame_error`, and leave `data_out` and `frame_valid` alone. A second case moves that edge just past the sample point but inside the minimum unit span, and the expected result is the same.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;

    // Decoder phases
    typedef enum logic [1:0] {
        ST_QUIET,   // waiting for a long enough high run on the wire
        ST_IDLE,    // armed, waiting for a falling edge
        ST_START,   // measuring the low start pulse
        ST_UNIT     // decoding four-bit units
    } dec_state_e;

    // Conditioned view of the wire for one sample
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

    // One information-bit sample handed to the capture stage
    typedef struct packed {
        logic stb;      // sample belongs to the capture window
        logic last;     // sample completes the window
        logic bit_val;  // sampled level
    } unit_smp_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pfd_line_edge.sv
`timescale 1ns/1ps
module pfd_line_edge
    import pfd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_line,
    output line_ev_t ev
);

    logic line_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_d <= 1'b1;
        end else begin
            line_d <= rx_line;
        end
    end

    always_comb begin
        ev.level = rx_line;
        ev.rise  = rx_line & ~line_d;
        ev.fall  = ~rx_line & line_d;
    end

endmodule

// File: rtl/pfd_frame_ctrl.sv
`timescale 1ns/1ps
module pfd_frame_ctrl
    import pfd_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int START_MIN = 6,
    parameter int START_MAX = 10,
    parameter int SAMPLE_AT = 5,
    parameter int UNIT_MIN  = 12,
    parameter int UNIT_MAX  = 20,
    parameter int QUIET_LEN = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  line_ev_t  ev,
    input  logic      slave_mode,
    output unit_smp_t smp,
    output logic      err_pulse
);

    localparam int UNITS   = 2 * DATA_W;
    localparam int IDX_W   = $clog2(UNITS);
    localparam int CNT_TOP = max_of(max_of(UNIT_MAX, QUIET_LEN), START_MAX);
    localparam int CNT_W   = $clog2(CNT_TOP + 1);

    localparam logic [CNT_W-1:0] C_ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_START_MIN = CNT_W'(START_MIN);
    localparam logic [CNT_W-1:0] C_START_MAX = CNT_W'(START_MAX);
    localparam logic [CNT_W-1:0] C_SAMPLE    = CNT_W'(SAMPLE_AT);
    localparam logic [CNT_W-1:0] C_UNIT_MIN  = CNT_W'(UNIT_MIN);
    localparam logic [CNT_W-1:0] C_UNIT_MAX  = CNT_W'(UNIT_MAX);
    localparam logic [CNT_W-1:0] C_QUIET_END = CNT_W'(QUIET_LEN - 1);
    localparam logic [IDX_W:0]   HALF        = (IDX_W+1)'(DATA_W);
    localparam logic [IDX_W:0]   IDX_ONE     = (IDX_W+1)'(1);

    dec_state_e       state;
    logic [CNT_W-1:0] tcnt;     // samples since the start of the current phase
    logic [IDX_W-1:0] uidx;     // unit number inside the frame
    logic             got;      // information bit of this unit already read

    logic [IDX_W:0] idx_x;
    logic [IDX_W:0] base_x;
    logic           in_win;
    logic           is_last;
    logic           sample_now;

    always_comb begin
        idx_x      = {1'b0, uidx};
        base_x     = slave_mode ? HALF : '0;
        in_win     = (idx_x >= base_x) && (idx_x < (base_x + HALF));
        is_last    = (idx_x == (base_x + HALF - IDX_ONE));
        // an edge on the sampling phase wins over the sample
        sample_now = (state == ST_UNIT) && !ev.rise && !got && (tcnt == C_SAMPLE);
        smp.stb     = sample_now && in_win;
        smp.last    = sample_now && is_last;
        smp.bit_val = ev.level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_QUIET;
            tcnt      <= '0;
            uidx      <= '0;
            got       <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= 1'b0;
            case (state)
                ST_QUIET: begin
                    if (ev.level) begin
                        if (tcnt == C_QUIET_END) begin
                            state <= ST_IDLE;
                            tcnt  <= '0;
                        end else begin
                            tcnt <= tcnt + C_ONE;
                        end
                    end else begin
                        tcnt <= '0;
                    end
                end
                ST_IDLE: begin
                    if (ev.fall) begin
                        state <= ST_START;
                        tcnt  <= C_ONE;
                    end
                end
                ST_START: begin
                    if (ev.level) begin
                        if (tcnt >= C_START_MIN) begin
                            state <= ST_UNIT;
                            tcnt  <= C_ONE;
                            uidx  <= '0;
                            got   <= 1'b0;
                        end else begin
                            err_pulse <= 1'b1;
                            state     <= ST_IDLE;
                            tcnt      <= '0;
                        end
                    end else if (tcnt == C_START_MAX) begin
                        err_pulse <= 1'b1;
                        state     <= ST_QUIET;
                        tcnt      <= '0;
                    end else begin
                        tcnt <= tcnt + C_ONE;
                    end
                end
                ST_UNIT: begin
                    if (ev.rise) begin
                        if (got && (tcnt >= C_UNIT_MIN)) begin
                            tcnt <= C_ONE;
                            uidx <= uidx + IDX_W'(1);
                            got  <= 1'b0;
                        end else begin
                            err_pulse <= 1'b1;
                            state     <= ST_QUIET;
                            tcnt      <= '0;
                        end
                    end else if (sample_now) begin
                        got <= 1'b1;
                        if (is_last) begin
                            state <= ST_QUIET;
                            tcnt  <= '0;
                        end else begin
                            tcnt <= tcnt + C_ONE;
                        end
                    end else if (tcnt == C_UNIT_MAX) begin
                        err_pulse <= 1'b1;
                        state     <= ST_QUIET;
                        tcnt      <= '0;
                    end else begin
                        tcnt <= tcnt + C_ONE;
                    end
                end
                default: begin
                    state <= ST_QUIET;
                    tcnt  <= '0;
                end
            endcase
        end
    end

    // R2
    unit_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_UNIT && $past(state) == ST_START) |-> ($past(tcnt) >= C_START_MIN));

    // R4
    sample_gap_chk: assert property (@(posedge clk) disable iff (rst)
        smp.stb |=> !smp.stb);

endmodule

// File: rtl/pfd_capture.sv
`timescale 1ns/1ps
module pfd_capture
    import pfd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  unit_smp_t         smp,
    output logic [DATA_W-1:0] data_out,
    output logic              frame_valid
);

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] shreg_nxt;

    // first unit of the window ends up in bit 0
    assign shreg_nxt = {smp.bit_val, shreg[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg       <= '0;
            data_out    <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= smp.last;
            if (smp.stb) begin
                shreg <= shreg_nxt;
            end
            if (smp.last) begin
                data_out <= shreg_nxt;
            end
        end
    end

    // R6
    frame_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_out) |-> frame_valid);

endmodule

// File: rtl/pulse_frame_rx.sv
`timescale 1ns/1ps
module pulse_frame_rx
    import pfd_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int START_MIN = 6,
    parameter int START_MAX = 10,
    parameter int SAMPLE_AT = 5,
    parameter int UNIT_MIN  = 12,
    parameter int UNIT_MAX  = 20,
    parameter int QUIET_LEN = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              slave_mode,
    output logic [DATA_W-1:0] data_out,
    output logic              frame_valid,
    output logic              frame_error
);

    line_ev_t  ev;
    unit_smp_t smp;

    pfd_line_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .rx_line (rx_line),
        .ev      (ev)
    );

    pfd_frame_ctrl #(
        .DATA_W    (DATA_W),
        .START_MIN (START_MIN),
        .START_MAX (START_MAX),
        .SAMPLE_AT (SAMPLE_AT),
        .UNIT_MIN  (UNIT_MIN),
        .UNIT_MAX  (UNIT_MAX),
        .QUIET_LEN (QUIET_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .slave_mode (slave_mode),
        .smp        (smp),
        .err_pulse  (frame_error)
    );

    pfd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk         (clk),
        .rst         (rst),
        .smp         (smp),
        .data_out    (data_out),
        .frame_valid (frame_valid)
    );

    // R8
    valid_error_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(frame_valid && frame_error));

endmodule

// File: tb/pulse_frame_rx_test.sv
`timescale 1ns/1ps
module pulse_frame_rx_test;

    logic       clk;
    logic       rst;
    logic       rx_line;
    logic       slave_mode;
    logic [7:0] data_out;
    logic       frame_valid;
    logic       frame_error;

    int checks = 0;
    int fails  = 0;
    int nval   = 0;
    int nerr   = 0;
    logic [7:0] seen_data = '0;

    pulse_frame_rx uut (
        .clk         (clk),
        .rst         (rst),
        .rx_line     (rx_line),
        .slave_mode  (slave_mode),
        .data_out    (data_out),
        .frame_valid (frame_valid),
        .frame_error (frame_error)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_valid) begin
                nval      = nval + 1;
                seen_data = data_out;
            end
            if (frame_error) nerr = nerr + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // start pulse, n units, line left low or released high
    task automatic send_frame(input logic [15:0] bits, input int n, input realtime bit_ns,
                              input realtime start_ns, input realtime tail_ns,
                              input bit end_high);
        rx_line = 1'b0;
        #(start_ns);
        for (int u = 0; u < n; u++) begin
            rx_line = 1'b1;
            #(bit_ns);
            rx_line = bits[u];
            #(bit_ns);
            rx_line = 1'b0;
            #(tail_ns);
        end
        if (end_high) rx_line = 1'b1;
    endtask

    task automatic align();
        @(posedge clk);
        #5;
    endtask

    task automatic pause_and_settle();
        rx_line = 1'b1;
        repeat (30) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_counts();
        nval = 0;
        nerr = 0;
    endtask

    task automatic normal_frame(input string req, input logic [15:0] bits, input int n,
                                input realtime bit_ns, input realtime tail_ns,
                                input logic [7:0] exp_data);
        clear_counts();
        align();
        send_frame(bits, n, bit_ns, 2.0 * bit_ns, tail_ns, 1'b1);
        pause_and_settle();
        chk({req, " valid count"}, nval, 1);
        chk({req, " error count"}, nerr, 0);
        chk({req, " data"}, seen_data, exp_data);
        chk({req, " data_out"}, data_out, exp_data);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        rx_line = 1'b1;
        slave_mode = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1 reset data_out", data_out, 0);
        chk("R1 reset frame_valid", frame_valid, 0);
        chk("R1 reset frame_error", frame_error, 0);
        rst = 1'b0;
    endtask

    // frame starts before 12 high samples were seen after reset
    task automatic t_quiet_after_reset();
        clear_counts();
        repeat (2) @(posedge clk);
        #5;
        send_frame(16'h00A5, 8, 80.0, 160.0, 160.0, 1'b1);
        pause_and_settle();
        chk("R1 early frame valid", nval, 0);
        chk("R1 early frame error", nerr, 0);
        chk("R1 early frame data_out", data_out, 0);
    endtask

    task automatic t_master_patterns();
        normal_frame("R6 R4 master A5", 16'h00A5, 8, 80.0, 160.0, 8'hA5);
        normal_frame("R4 all closed", 16'h0000, 8, 80.0, 160.0, 8'h00);
        normal_frame("R4 all open", 16'h00FF, 8, 80.0, 160.0, 8'hFF);
    endtask

    task automatic t_slave();
        @(negedge clk);
        slave_mode = 1'b1;
        normal_frame("R7 slave half", 16'h3CC3, 16, 80.0, 160.0, 8'h3C);
        @(negedge clk);
        slave_mode = 1'b0;
    endtask

    task automatic t_master_long_frame();
        normal_frame("R11 master on 16-unit frame", 16'hFF96, 16, 80.0, 160.0, 8'h96);
    endtask

    task automatic t_short_start();
        clear_counts();
        align();
        rx_line = 1'b0;
        #60;
        rx_line = 1'b1;
        #100;
        send_frame(16'h005A, 8, 80.0, 160.0, 160.0, 1'b1);
        pause_and_settle();
        chk("R2 glitch error", nerr, 1);
        chk("R2 following frame valid", nval, 1);
        chk("R2 following frame data", data_out, 8'h5A);
    endtask

    task automatic t_long_start();
        clear_counts();
        align();
        send_frame(16'h0011, 8, 80.0, 280.0, 160.0, 1'b1);
        pause_and_settle();
        chk("R3 long start error", nerr, 1);
        chk("R3 long start valid", nval, 0);
        chk("R8 data kept after long start", data_out, 8'h5A);
    endtask

    task automatic t_truncated();
        clear_counts();
        align();
        send_frame(16'h00F0, 5, 80.0, 160.0, 160.0, 1'b0);
        #600;
        pause_and_settle();
        chk("R8 truncated error", nerr, 1);
        chk("R8 truncated valid", nval, 0);
        chk("R8 truncated data kept", data_out, 8'h5A);
    endtask

    task automatic t_resync_spans();
        normal_frame("R5 long unit span", 16'h0033, 8, 80.0, 200.0, 8'h33);
        normal_frame("R5 short unit span", 16'h00CC, 8, 80.0, 100.0, 8'hCC);
        clear_counts();
        align();
        send_frame(16'h0055, 8, 80.0, 160.0, 300.0, 1'b1);
        pause_and_settle();
        chk("R5 over-long span error", nerr, 1);
        chk("R5 over-long span valid", nval, 0);
    endtask

    // next rising edge seen exactly on the sampling phase
    task automatic t_edge_on_sample();
        clear_counts();
        align();
        rx_line = 1'b0;
        #160;
        rx_line = 1'b1;
        #80;
        rx_line = 1'b0;
        #20;
        rx_line = 1'b1;
        #80;
        rx_line = 1'b0;
        #160;
        pause_and_settle();
        chk("R9 edge on sample error", nerr, 1);
        chk("R9 edge on sample valid", nval, 0);
        chk("R9 edge on sample data kept", data_out, 8'hCC);
    endtask

    task automatic t_edge_too_early();
        clear_counts();
        align();
        rx_line = 1'b0;
        #160;
        rx_line = 1'b1;
        #80;
        rx_line = 1'b0;
        #80;
        rx_line = 1'b1;
        #80;
        rx_line = 1'b0;
        #160;
        pause_and_settle();
        chk("R9 early edge error", nerr, 1);
        chk("R9 early edge valid", nval, 0);
    endtask

    task automatic t_tolerance();
        normal_frame("R10 fast transmitter", 16'h0069, 8, 68.0, 136.0, 8'h69);
        normal_frame("R10 slow transmitter", 16'h00E1, 8, 92.0, 184.0, 8'hE1);
    endtask

    initial begin
        t_reset();
        t_quiet_after_reset();
        t_master_patterns();
        t_slave();
        t_master_long_frame();
        t_short_start();
        t_long_start();
        t_truncated();
        t_resync_spans();
        t_edge_on_sample();
        t_edge_too_early();
        t_tolerance();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog (all R) actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule